// File: doc/BRIEF.md
# Commutative-Update Line Reduction Controller

This block models one shared cache line that several cores may update at the same time through commutative operators. A core issues a labeled request (add, unsigned minimum or bitwise OR). The request is served against that core's own private partial copy of the line, so no copy is invalidated and no other core is disturbed. The first core to take the line under a label receives the line's real contents. Every core that joins afterwards starts from the operator's identity value.

An unlabeled request, or a labeled request whose operator differs from the line's current label, starts a reduction. The controller walks the cores one per clock and merges each live partial copy into an accumulator, element by element across every element of the line. While it does this it raises `busy` and accepts no new request. The merged line then becomes the line's single value. The pending request is served against it. The line goes back to unlabeled, owned by the requester, or is relabeled with the requester holding the merged value.

Each core has a request port: valid, write flag, label, element index and write data. Each core also has a response strobe, and all cores share one read-data bus. Unlabeled writes that overwrite a line other cores have read with plain reads flag those cores through a per-core conflict pulse.

Top module: `comm_line_reducer`

## Requirements
- R1: After reset `busy`, every `rsp_valid` and every `conflict` bit are low, the line is unlabeled, and every element reads as zero.
- R2: When several cores request in the same cycle and the controller is idle, the lowest-numbered core is served first. At most one `rsp_valid` bit is high in any cycle.
- R3: An unlabeled request on an unlabeled line responds one cycle after acceptance. A read returns the stored element. A write stores `wdata` at the element and returns it.
- R4: A labeled request (label encoding 01 = add, 10 = unsigned minimum, 11 = OR; 00 = unlabeled) whose label equals the line's label responds one cycle after acceptance, never raises `busy`, and raises no `conflict` bit.
- R5: The first core to label an unlabeled line gets a copy equal to the stored line. A core that joins later gets a copy filled with the identity: 0 for add and OR, all ones for minimum.
- R6: A labeled write changes only the requester's own partial copy. A labeled read returns an element of the requester's own copy.
- R7: An unlabeled request on a labeled line starts a reduction. `busy` is high for exactly N_CORES cycles, and the response comes in the cycle `busy` falls, N_CORES+1 cycles after acceptance.
- R8: A reduction merges, for every element index, all live partial copies with the line's operator: add wraps modulo 2^32, minimum is unsigned, OR is bitwise.
- R9: A labeled request whose label differs from the line's current label first reduces, then relabels the line with the new label. The requester's copy holds the merged line, and the request is applied to that copy.
- R10: After an unlabeled request completes a reduction, the line is unlabeled and every partial copy is dropped. The next labeled joiner receives the merged value as the line's real contents.
- R11: An unlabeled write pulses `conflict`, in its response cycle, for every other core that made a plain read of the line since the last plain write. The writer itself is never flagged.
- R12: While `busy` is high no request is accepted and no response is given. A held request is served after the reduction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CORES | Per-core request valid, held until that core's response |
| req_write | input | N_CORES | Per-core write flag |
| req_label | input | 2*N_CORES | Per-core label, 2 bits each (00 none, 01 add, 10 min, 11 OR) |
| req_idx | input | log2(ELEMS)*N_CORES | Per-core element index |
| req_wdata | input | ELEM_W*N_CORES | Per-core write data |
| rsp_valid | output | N_CORES | One-cycle response strobe per core |
| rsp_rdata | output | ELEM_W | Response data for the strobed core |
| conflict | output | N_CORES | One-cycle per-core conflict pulse |
| busy | output | 1 | Reduction in progress; requests stall |

## Verification
A wrong partial copy stays hidden while the line keeps its label. It shows up at the ports only when a labeled read by the same core returns it, or when the next reduction folds it into the merged value. That can be many requests later, so the bench interleaves plain reads at random to force reductions often. A wrong label or copy-valid bit shows up sooner and more directly: the response comes in the wrong number of cycles (one versus N_CORES+1), or a joining core's first read returns the wrong identity. Sharer errors show up only as a missing or extra `conflict` pulse on the next plain write.

// File: rtl/comm_red_pkg.sv
package comm_red_pkg;

    typedef enum logic [1:0] {
        LBL_NONE = 2'b00,
        LBL_ADD  = 2'b01,
        LBL_MIN  = 2'b10,
        LBL_OR   = 2'b11
    } lbl_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_REDUCE = 1'b1
    } phase_e;

endpackage

// File: rtl/comm_prio_arb.sv
module comm_prio_arb #(
    parameter int N = 4
) (
    input  logic                 en,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_id,
    output logic                 any
);
    localparam int ID_W = $clog2(N);

    // Scan downward so the lowest requesting index is the last one written.
    always_comb begin
        gnt    = '0;
        gnt_id = '0;
        any    = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en && req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                gnt_id = ID_W'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/comm_lane_merge.sv
module comm_lane_merge
    import comm_red_pkg::*;
#(
    parameter int ELEMS  = 4,
    parameter int ELEM_W = 32
) (
    input  lbl_e                      op,
    input  logic [ELEMS*ELEM_W-1:0]   a,
    input  logic [ELEMS*ELEM_W-1:0]   b,
    output logic [ELEMS*ELEM_W-1:0]   y
);
    // One combining lane per element position of the line.
    for (genvar e = 0; e < ELEMS; e++) begin : g_lane
        logic [ELEM_W-1:0] ea, eb, ey;
        assign ea = a[e*ELEM_W +: ELEM_W];
        assign eb = b[e*ELEM_W +: ELEM_W];
        always_comb begin
            unique case (op)
                LBL_ADD: ey = ea + eb;
                LBL_MIN: ey = (ea < eb) ? ea : eb;
                LBL_OR:  ey = ea | eb;
                default: ey = ea;
            endcase
        end
        assign y[e*ELEM_W +: ELEM_W] = ey;
    end

endmodule

// File: rtl/comm_line_reducer.sv
module comm_line_reducer
    import comm_red_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ELEMS   = 4,
    parameter int ELEM_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_CORES-1:0]                req_valid,
    input  logic [N_CORES-1:0]                req_write,
    input  logic [2*N_CORES-1:0]              req_label,
    input  logic [$clog2(ELEMS)*N_CORES-1:0]  req_idx,
    input  logic [ELEM_W*N_CORES-1:0]         req_wdata,
    output logic [N_CORES-1:0]                rsp_valid,
    output logic [ELEM_W-1:0]                 rsp_rdata,
    output logic [N_CORES-1:0]                conflict,
    output logic                              busy
);
    localparam int IDX_W  = $clog2(ELEMS);
    localparam int CID_W  = $clog2(N_CORES);
    localparam int LINE_W = ELEMS * ELEM_W;
    localparam int RUN_W  = $clog2(N_CORES + 2);

    typedef struct packed {
        logic [CID_W-1:0]  core;
        logic              write;
        lbl_e              lbl;
        logic [IDX_W-1:0]  idx;
        logic [ELEM_W-1:0] data;
    } req_t;

    typedef struct packed {
        phase_e                           phase;
        logic [CID_W-1:0]                 cnt;
        lbl_e                             label;
        logic [LINE_W-1:0]                home;
        logic [LINE_W-1:0]                acc;
        logic [N_CORES-1:0]               valid;
        logic [N_CORES-1:0]               sharer;
        logic [N_CORES-1:0][LINE_W-1:0]   copies;
        req_t                             pend;
        logic [N_CORES-1:0]               rsp_valid;
        logic [ELEM_W-1:0]                rsp_rdata;
        logic [N_CORES-1:0]               conflict;
    } state_t;

    function automatic logic [LINE_W-1:0] ident_line(lbl_e l);
        return (l == LBL_MIN) ? {LINE_W{1'b1}} : {LINE_W{1'b0}};
    endfunction

    state_t s_d, s_q;

    // ---------------------------------------------------------------
    // Request selection
    // ---------------------------------------------------------------
    logic [N_CORES-1:0] gnt;
    logic [CID_W-1:0]   gnt_id;
    logic               any_gnt;

    comm_prio_arb #(.N(N_CORES)) i_arb (
        .en     (s_q.phase == PH_IDLE),
        .req    (req_valid),
        .gnt    (gnt),
        .gnt_id (gnt_id),
        .any    (any_gnt)
    );

    req_t in_req;
    always_comb begin
        in_req.core  = gnt_id;
        in_req.write = req_write[gnt_id];
        in_req.lbl   = lbl_e'(req_label[2*gnt_id +: 2]);
        in_req.idx   = req_idx[IDX_W*gnt_id +: IDX_W];
        in_req.data  = req_wdata[ELEM_W*gnt_id +: ELEM_W];
    end

    // ---------------------------------------------------------------
    // Reduction datapath: fold the copy of core cnt into the accumulator
    // ---------------------------------------------------------------
    logic [LINE_W-1:0] merged;

    comm_lane_merge #(.ELEMS(ELEMS), .ELEM_W(ELEM_W)) i_merge (
        .op (s_q.label),
        .a  (s_q.acc),
        .b  (s_q.copies[s_q.cnt]),
        .y  (merged)
    );

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    state_t             w;
    req_t               srv;
    logic               do_serve;
    logic               needs_reduce;
    logic [LINE_W-1:0]  acc_next;
    logic [N_CORES-1:0] self_bit;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = '0;
        s_d.conflict  = '0;
        w             = s_q;
        w.rsp_valid   = '0;
        w.conflict    = '0;
        srv           = in_req;
        do_serve      = 1'b0;
        acc_next      = s_q.valid[s_q.cnt] ? merged : s_q.acc;
        needs_reduce  = (s_q.label != LBL_NONE) && (in_req.lbl != s_q.label);
        self_bit      = '0;

        if (s_q.phase == PH_IDLE) begin
            if (any_gnt && needs_reduce) begin
                s_d.phase = PH_REDUCE;
                s_d.cnt   = '0;
                s_d.acc   = ident_line(s_q.label);
                s_d.pend  = in_req;
            end else if (any_gnt) begin
                do_serve = 1'b1;
            end
        end else begin
            s_d.acc = acc_next;
            if (s_q.cnt == CID_W'(N_CORES - 1)) begin
                w.phase  = PH_IDLE;
                w.cnt    = '0;
                w.acc    = acc_next;
                w.home   = acc_next;
                w.valid  = '0;
                w.sharer = '0;
                w.label  = LBL_NONE;
                srv      = s_q.pend;
                do_serve = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (do_serve) begin
            self_bit[srv.core] = 1'b1;
            if (srv.lbl == LBL_NONE) begin
                if (srv.write) begin
                    w.conflict = w.sharer & ~self_bit;
                    w.sharer   = self_bit;
                    w.home[ELEM_W*srv.idx +: ELEM_W] = srv.data;
                    w.rsp_rdata = srv.data;
                end else begin
                    w.sharer    = w.sharer | self_bit;
                    w.rsp_rdata = w.home[ELEM_W*srv.idx +: ELEM_W];
                end
            end else begin
                if (w.label == LBL_NONE) begin
                    w.label            = srv.lbl;
                    w.sharer           = '0;
                    w.valid[srv.core]  = 1'b1;
                    w.copies[srv.core] = w.home;
                end else if (!w.valid[srv.core]) begin
                    w.valid[srv.core]  = 1'b1;
                    w.copies[srv.core] = ident_line(srv.lbl);
                end
                if (srv.write) begin
                    w.copies[srv.core][ELEM_W*srv.idx +: ELEM_W] = srv.data;
                    w.rsp_rdata = srv.data;
                end else begin
                    w.rsp_rdata = w.copies[srv.core][ELEM_W*srv.idx +: ELEM_W];
                end
            end
            w.rsp_valid = self_bit;
            s_d         = w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_rdata = s_q.rsp_rdata;
    assign conflict  = s_q.conflict;
    assign busy      = (s_q.phase != PH_IDLE);

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic [RUN_W-1:0] busy_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run_q <= '0;
        else if (busy) busy_run_q <= busy_run_q + 1'b1;
        else           busy_run_q <= '0;
    end

    assert_one_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run_q == RUN_W'(N_CORES)));

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= RUN_W'(N_CORES));

    assert_rsp_after_reduce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($countones(rsp_valid) == 1));

    assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rsp_valid == '0));

    assert_no_self_conflict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict & rsp_valid) == '0);

    assert_conflict_with_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict != '0) |-> (rsp_valid != '0));

endmodule

// File: tb/test_comm_line_reducer.sv
module test_comm_line_reducer;
    localparam int N  = 4;
    localparam int E  = 4;
    localparam int W  = 32;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [N-1:0]      req_write = '0;
    logic [2*N-1:0]    req_label = '0;
    logic [IW*N-1:0]   req_idx = '0;
    logic [W*N-1:0]    req_wdata = '0;
    logic [N-1:0]      rsp_valid;
    logic [W-1:0]      rsp_rdata;
    logic [N-1:0]      conflict;
    logic              busy;

    comm_line_reducer #(.N_CORES(N), .ELEMS(E), .ELEM_W(W)) i_comm_line_reducer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_label(req_label), .req_idx(req_idx), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .conflict(conflict), .busy(busy)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model
    logic [W-1:0] m_home [E];
    logic [W-1:0] m_copy [N][E];
    bit           m_valid [N];
    bit           m_sharer [N];
    int           m_label;

    function automatic logic [W-1:0] ident(int l);
        return (l == 2) ? '1 : '0;
    endfunction

    function automatic logic [W-1:0] comb(int l, logic [W-1:0] a, logic [W-1:0] b);
        case (l)
            1: return a + b;
            2: return (a < b) ? a : b;
            3: return a | b;
            default: return a;
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_apply(input int c, input bit wr, input int lbl, input int idx,
                               input logic [W-1:0] d, output logic [W-1:0] rd,
                               output logic [N-1:0] cf, output bit red);
        logic [W-1:0] acc;
        red = (m_label != 0) && (lbl != m_label);
        cf  = '0;
        if (red) begin
            for (int e = 0; e < E; e++) begin
                acc = ident(m_label);
                for (int k = 0; k < N; k++)
                    if (m_valid[k]) acc = comb(m_label, acc, m_copy[k][e]);
                m_home[e] = acc;
            end
            for (int k = 0; k < N; k++) begin m_valid[k] = 0; m_sharer[k] = 0; end
            m_label = 0;
        end
        if (lbl == 0) begin
            if (wr) begin
                for (int k = 0; k < N; k++) begin
                    if (m_sharer[k] && k != c) cf[k] = 1'b1;
                    m_sharer[k] = (k == c);
                end
                m_home[idx] = d;
                rd = d;
            end else begin
                m_sharer[c] = 1;
                rd = m_home[idx];
            end
        end else begin
            if (m_label == 0) begin
                m_label = lbl;
                for (int k = 0; k < N; k++) m_sharer[k] = 0;
                m_valid[c] = 1;
                for (int e = 0; e < E; e++) m_copy[c][e] = m_home[e];
            end else if (!m_valid[c]) begin
                m_valid[c] = 1;
                for (int e = 0; e < E; e++) m_copy[c][e] = ident(lbl);
            end
            if (wr) begin m_copy[c][idx] = d; rd = d; end
            else rd = m_copy[c][idx];
        end
    endtask

    task automatic drive(int c, bit wr, int lbl, int idx, logic [W-1:0] d);
        req_write[c]         = wr;
        req_label[2*c +: 2]  = 2'(lbl);
        req_idx[IW*c +: IW]  = IW'(idx);
        req_wdata[W*c +: W]  = d;
        req_valid[c]         = 1'b1;
    endtask

    // One request from one core, checked for data, latency and conflicts.
    task automatic do_req(int c, bit wr, int lbl, int idx, logic [W-1:0] d, string tag);
        logic [W-1:0] erd;
        logic [N-1:0] ecf;
        bit           red;
        int           cyc;
        int           elat;
        model_apply(c, wr, lbl, idx, d, erd, ecf, red);
        elat = red ? N + 1 : 1;
        @(negedge clk);
        drive(c, wr, lbl, idx, d);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!rsp_valid[c] && cyc < 40);
        req_valid[c] = 1'b0;
        check(cyc == elat, {tag, " latency"}, W'(cyc), W'(elat));
        check(rsp_rdata == erd, {tag, " data"}, rsp_rdata, erd);
        check(conflict == ecf, {tag, " conflict"}, W'(conflict), W'(ecf));
    endtask

    function automatic string tag_of(int lbl, bit wr);
        if (m_label != 0 && lbl != m_label) return (lbl == 0) ? "R7" : "R9";
        if (lbl == 0) return wr ? "R11" : "R3";
        return "R4";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] rd0, rd1, rd3;
        logic [N-1:0] cf0;
        bit           rdc;
        int           seed;
        int           t0;
        for (int e = 0; e < E; e++) m_home[e] = '0;
        for (int k = 0; k < N; k++) begin m_valid[k] = 0; m_sharer[k] = 0; end
        m_label = 0;
        seed = $urandom(32'h5eed_1234);

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", W'(busy), 0);
        check(rsp_valid == '0, "R1 rsp_valid", W'(rsp_valid), 0);
        check(conflict == '0, "R1 conflict", W'(conflict), 0);
        do_req(0, 0, 0, 2, '0, "R1 read zero");

        // R3 plain writes and reads
        do_req(0, 1, 0, 0, 32'd20, "R3 write");
        do_req(1, 1, 0, 1, 32'd100, "R3 write");
        do_req(2, 1, 0, 2, 32'h0000_00f0, "R3 write");
        do_req(3, 1, 0, 3, 32'hffff_fff0, "R3 write");
        do_req(2, 0, 0, 0, '0, "R3 read");

        // R5/R6 add example: 20 + (1+1) on core0, 0 + (1+1) on core1
        do_req(0, 0, 1, 0, '0, "R5 first joiner gets stored value");
        do_req(0, 1, 1, 0, 32'd21, "R4 labeled write");
        do_req(1, 0, 1, 0, '0, "R5 add identity");
        do_req(1, 1, 1, 0, 32'd1, "R6 own copy");
        do_req(1, 1, 1, 3, 32'd20, "R6 own copy");
        do_req(0, 1, 1, 0, 32'd22, "R6 own copy");
        do_req(1, 1, 1, 0, 32'd2, "R6 own copy");
        do_req(0, 0, 1, 0, '0, "R6 core0 copy intact");
        // R7 plain read reduces: expect 24
        do_req(2, 0, 0, 0, '0, "R7 reduce add");
        check(m_home[0] == 32'd24, "R7 model sum", m_home[0], 32'd24);
        do_req(2, 0, 0, 3, '0, "R8 element 3 wraps");
        do_req(2, 0, 0, 1, '0, "R8 element 1");
        // R10 next labeled joiner gets merged value
        do_req(3, 0, 2, 0, '0, "R10 joiner gets merged");
        do_req(1, 0, 2, 2, '0, "R5 min identity");
        do_req(1, 1, 2, 2, 32'h0000_0007, "R4 min write");
        do_req(3, 1, 2, 2, 32'h0000_0040, "R4 min write");
        // R9 different label triggers reduction then relabel
        do_req(0, 0, 3, 2, '0, "R9 relabel min to or");
        do_req(0, 1, 3, 1, 32'h0000_0f00, "R4 or write");
        do_req(2, 0, 3, 1, '0, "R5 or identity");
        do_req(2, 1, 3, 1, 32'h0000_000f, "R4 or write");
        do_req(1, 0, 0, 1, '0, "R8 or reduce");
        // R11 conflict on plain write after plain reads
        do_req(2, 0, 0, 0, '0, "R3 read");
        do_req(3, 0, 0, 0, '0, "R3 read");
        do_req(3, 1, 0, 2, 32'd5, "R11 conflict");
        do_req(3, 1, 0, 2, 32'd6, "R11 no conflict");

        // R2 simultaneous requests from cores 1 and 3
        model_apply(1, 0, 0, 1, '0, rd1, cf0, rdc);
        model_apply(3, 0, 0, 2, '0, rd3, cf0, rdc);
        @(negedge clk);
        drive(1, 0, 0, 1, '0);
        drive(3, 0, 0, 2, '0);
        @(negedge clk);
        check(rsp_valid == 4'b0010, "R2 lowest first", W'(rsp_valid), 32'b0010);
        check(rsp_rdata == rd1, "R2 data", rsp_rdata, rd1);
        req_valid[1] = 1'b0;
        @(negedge clk);
        check(rsp_valid == 4'b1000, "R2 second served", W'(rsp_valid), 32'b1000);
        check(rsp_rdata == rd3, "R2 data", rsp_rdata, rd3);
        req_valid[3] = 1'b0;

        // R12 stall: core0 reduces while core1 waits
        do_req(0, 1, 1, 0, 32'd9, "R4 add join");
        do_req(2, 1, 1, 0, 32'd4, "R5 add join");
        model_apply(0, 0, 0, 0, '0, rd0, cf0, rdc);
        model_apply(1, 0, 0, 0, '0, rd1, cf0, rdc);
        @(negedge clk);
        drive(0, 0, 0, 0, '0);
        drive(1, 0, 0, 0, '0);
        t0 = 0;
        do begin
            @(negedge clk);
            t0++;
            if (!rsp_valid[0]) check(rsp_valid[1] == 1'b0, "R12 held during busy",
                                     W'(rsp_valid), 0);
        end while (!rsp_valid[0] && t0 < 40);
        check(t0 == N + 1, "R12 reducer latency", W'(t0), W'(N + 1));
        check(rsp_rdata == rd0, "R12 reduced data", rsp_rdata, rd0);
        check(busy == 1'b0, "R12 busy low at rsp", W'(busy), 0);
        req_valid[0] = 1'b0;
        @(negedge clk);
        check(rsp_valid == 4'b0010, "R12 held request served", W'(rsp_valid), 32'b0010);
        check(rsp_rdata == rd1, "R12 held data", rsp_rdata, rd1);
        req_valid[1] = 1'b0;

        // Random mix against the model
        for (int n = 0; n < 600; n++) begin
            int c, l, ix;
            bit wr;
            logic [W-1:0] d;
            c  = int'($urandom_range(N - 1));
            l  = int'($urandom_range(3));
            ix = int'($urandom_range(E - 1));
            wr = 1'($urandom_range(1));
            d  = ($urandom_range(3) == 0) ? $urandom : W'($urandom_range(255));
            do_req(c, wr, l, ix, d, tag_of(l, wr));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule